// File: doc/BRIEF.md
# Serial ADC Sample Reader

This block is the host-side master for a three-wire serial analog-to-digital converter. A start request drives the active-low chip select low. The block then makes a serial clock by dividing the system clock and samples the converter's data line on each rising serial clock edge. The converter changes the data line on falling edges. Each frame begins with four zero bits. The reader drops them and checks that they really are zero. It then shifts in the result, most significant bit first, and raises chip select once the last result bit has been sampled.

The result is presented right-aligned with a one-cycle valid strobe. A flag reports a frame whose leading bits were not all zero. Resolution is a parameter: 12, 10 or 8 result bits, which gives 16, 14 or 12 serial clocks per frame. The serial clock must keep running for the whole frame, because the converter uses it as its conversion clock. Between frames the reader holds chip select high for a guaranteed minimum time. Start requests that arrive while a frame or that quiet time is in progress are dropped.

Top module: `adc_frame_reader`

## Requirements
- R1: While rst_ni is low and after its release, cs_n_o and sclk_o are 1, and busy_o and valid_o are 0.
- R2: A start_i seen high in idle pulls cs_n_o low one cycle later. sclk_o then stays high for SCLK_DIV cycles and afterwards toggles, with each high or low half lasting SCLK_DIV system cycles.
- R3: A frame contains exactly 4+RES_BITS rising edges of sclk_o. cs_n_o returns high SCLK_DIV cycles after the last rising edge, with sclk_o left high.
- R4: sdata_i is sampled at each rising edge of sclk_o. The first 4 samples are discarded. The next RES_BITS samples form data_o, with the first sample in bit RES_BITS-1 and the last in bit 0.
- R5: valid_o is high for exactly one cycle, the cycle in which cs_n_o returns high. data_o keeps its value until the next valid_o.
- R6: prefix_err_o is 1 after a frame in which any of the first 4 samples was 1, and 0 otherwise. The result is still delivered. The flag keeps its value until the next frame starts.
- R7: start_i has no effect while busy_o is 1. busy_o is 1 from the cycle cs_n_o falls until the end of the quiet time.
- R8: After cs_n_o rises it stays high for at least 2*GAP_PERIODS*SCLK_DIV cycles. A start_i held high starts the next frame one cycle after busy_o drops.
- R9: sclk_o is 1 whenever cs_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a conversion frame |
| sdata_i | input | 1 | Serial data from converter |
| cs_n_o | output | 1 | Chip select to converter, active low |
| sclk_o | output | 1 | Serial clock to converter |
| busy_o | output | 1 | Frame or quiet time in progress |
| data_o | output | RES_BITS | Last result, right-aligned |
| valid_o | output | 1 | One-cycle strobe with a new result |
| prefix_err_o | output | 1 | Leading bits of last frame were not all zero |

## Verification
The converter model sends several result words. A word alternating in nibbles and the all-ones and all-zeros words show bit order and sampling phase. Single-bit words at the MSB and the LSB separate an off-by-one in the skip count from a shifted alignment. Frames with one prefix bit set, including the bit just before the MSB, show that the error check covers the whole prefix and does not corrupt the result. A clean frame after such a frame shows that the flag clears. Start pulses in the middle of a frame and during the quiet time, and a start held high, show that requests are dropped and the minimum chip-select-high time is enforced.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP
  } rd_state_e;
endpackage

// File: rtl/adc_rd_divider.sv
module adc_rd_divider #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned PREFIX      = 4,
  parameter int unsigned RES_BITS    = 12,
  parameter int unsigned GAP_PERIODS = 2,
  localparam int unsigned FRAME      = PREFIX + RES_BITS,
  localparam int unsigned BW         = $clog2(FRAME + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tick_i,
  output logic          clr_o,
  output logic          cs_n_o,
  output logic          sclk_o,
  output logic          busy_o,
  output logic          sample_o,
  output logic [BW-1:0] bit_idx_o,
  output logic          frame_start_o,
  output logic          frame_done_o
);
  localparam int unsigned GAP_HALVES = 2 * GAP_PERIODS;
  localparam int unsigned GW         = $clog2(GAP_HALVES + 1);

  rd_state_e     state_q;
  logic          cs_n_q, sclk_q;
  logic [BW-1:0] bits_q;
  logic [GW-1:0] gap_q;
  logic          last_bit;

  assign last_bit      = (bits_q == BW'(FRAME - 1));
  assign clr_o         = (state_q == ST_IDLE);
  assign frame_start_o = (state_q == ST_IDLE) && start_i;
  assign sample_o      = (state_q == ST_SHIFT) && tick_i && !sclk_q;
  assign frame_done_o  = (state_q == ST_HOLD) && tick_i;
  assign cs_n_o        = cs_n_q;
  assign sclk_o        = sclk_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign bit_idx_o     = bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b1;
      bits_q  <= '0;
      gap_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SETUP;
          cs_n_q  <= 1'b0;
          bits_q  <= '0;
        end
        ST_SETUP: if (tick_i) begin
          state_q <= ST_SHIFT;
          sclk_q  <= 1'b0;
        end
        ST_SHIFT: if (tick_i) begin
          if (!sclk_q) begin
            // rising edge: sample point
            sclk_q <= 1'b1;
            bits_q <= bits_q + 1'b1;
            if (last_bit) state_q <= ST_HOLD;
          end else begin
            sclk_q <= 1'b0;
          end
        end
        ST_HOLD: if (tick_i) begin
          cs_n_q  <= 1'b1;
          state_q <= ST_GAP;
          gap_q   <= '0;
        end
        ST_GAP: if (tick_i) begin
          if (gap_q == GW'(GAP_HALVES - 1)) state_q <= ST_IDLE;
          else                              gap_q   <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  bit_count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_q <= BW'(FRAME));

  // R7
  no_start_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !$fell(cs_n_o));

  // R2
  cs_fall_clk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> sclk_o);

  // R8
  gap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> (cs_n_q && sclk_q));
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int unsigned PREFIX   = 4,
  parameter int unsigned RES_BITS = 12,
  parameter int unsigned BW       = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sdata_i,
  input  logic                sample_i,
  input  logic [BW-1:0]       bit_idx_i,
  input  logic                frame_start_i,
  input  logic                frame_done_i,
  output logic [RES_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                err_o
);
  logic [RES_BITS-1:0] sh_q, data_q;
  logic                valid_q, err_q;
  logic                in_prefix;

  assign in_prefix = (bit_idx_i < BW'(PREFIX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= frame_done_i;
      if (frame_start_i) err_q <= 1'b0;
      if (sample_i) begin
        if (in_prefix) begin
          if (sdata_i) err_q <= 1'b1;
        end else begin
          sh_q <= {sh_q[RES_BITS-2:0], sdata_i};
        end
      end
      if (frame_done_i) data_q <= sh_q;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  // R5
  valid_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int unsigned RES_BITS    = 12,
  parameter int unsigned SCLK_DIV    = 4,
  parameter int unsigned GAP_PERIODS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                sdata_i,
  output logic                cs_n_o,
  output logic                sclk_o,
  output logic                busy_o,
  output logic [RES_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                prefix_err_o
);
  localparam int unsigned PREFIX = 4;
  localparam int unsigned FRAME  = PREFIX + RES_BITS;
  localparam int unsigned BW     = $clog2(FRAME + 1);

  logic          tick, clr, sample, frame_start, frame_done;
  logic [BW-1:0] bit_idx;

  adc_rd_divider #(.DIV(SCLK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_o (tick)
  );

  adc_rd_ctrl #(
    .PREFIX      (PREFIX),
    .RES_BITS    (RES_BITS),
    .GAP_PERIODS (GAP_PERIODS)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .tick_i        (tick),
    .clr_o         (clr),
    .cs_n_o        (cs_n_o),
    .sclk_o        (sclk_o),
    .busy_o        (busy_o),
    .sample_o      (sample),
    .bit_idx_o     (bit_idx),
    .frame_start_o (frame_start),
    .frame_done_o  (frame_done)
  );

  adc_rd_shift #(
    .PREFIX   (PREFIX),
    .RES_BITS (RES_BITS),
    .BW       (BW)
  ) u_shift (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sdata_i       (sdata_i),
    .sample_i      (sample),
    .bit_idx_i     (bit_idx),
    .frame_start_i (frame_start),
    .frame_done_i  (frame_done),
    .data_o        (data_o),
    .valid_o       (valid_o),
    .err_o         (prefix_err_o)
  );

  // R9
  idle_clk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> sclk_o);

  // R5
  valid_at_cs_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(cs_n_o));
endmodule

// File: tb/tb_adc_frame_reader.sv
module tb_adc_frame_reader;
  localparam int RES   = 12;
  localparam int DIV   = 4;
  localparam int GAPP  = 2;
  localparam int FRAME = 4 + RES;
  localparam int CS_UP = (2 * FRAME + 1) * DIV;
  localparam int TOTAL = CS_UP + 2 * GAPP * DIV;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic           sdata_i = 1'b0;
  logic           cs_n_o, sclk_o, busy_o, valid_o, prefix_err_o;
  logic [RES-1:0] data_o;

  always #10 clk = ~clk;

  adc_frame_reader #(.RES_BITS(RES), .SCLK_DIV(DIV), .GAP_PERIODS(GAPP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .sdata_i(sdata_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_o(busy_o), .data_o(data_o),
    .valid_o(valid_o), .prefix_err_o(prefix_err_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // converter stimulus: tx_bits[FRAME-1] goes out first
  logic [FRAME-1:0] tx_bits = '0;
  logic [RES-1:0]   m_word;
  logic             m_perr;
  logic [RES-1:0]   m_data = '0;
  logic             m_err = 1'b0;
  bit               m_busy = 0;
  int               m_t = 0;
  int               fall_cnt = 0;
  logic             prev_sclk = 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model: time since frame acceptance
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_busy = 0; m_t = 0;
    end else if (m_busy) begin
      m_t++;
      if (m_t == CS_UP) begin
        m_data = tx_bits[RES-1:0];
        m_err  = |tx_bits[FRAME-1:RES];
      end
      if (m_t == TOTAL) m_busy = 0;
    end else if (start_i) begin
      m_busy = 1; m_t = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic e_cs, e_sclk, e_valid;
      e_cs = 1'b1; e_sclk = 1'b1; e_valid = 1'b0;
      if (m_busy) begin
        e_cs    = (m_t >= CS_UP);
        e_sclk  = !(m_t >= DIV && m_t < 2 * FRAME * DIV && ((m_t - DIV) / DIV) % 2 == 0);
        e_valid = (m_t == CS_UP);
      end
      chk("R2 R3 cs_n", cs_n_o, e_cs);
      chk("R2 R9 sclk", sclk_o, e_sclk);
      chk("R7 R8 busy", busy_o, m_busy);
      chk("R5 valid", valid_o, e_valid);
      chk("R4 R5 data", data_o, m_data);
      if (!m_busy || e_valid) chk("R6 prefix_err", prefix_err_o, m_err);
    end
    // converter model: next bit after each falling edge
    if (cs_n_o) begin
      fall_cnt = 0; sdata_i = 1'b0;
    end else if (prev_sclk && !sclk_o) begin
      sdata_i = (fall_cnt < FRAME) ? tx_bits[FRAME-1-fall_cnt] : 1'b0;
      fall_cnt++;
    end
    prev_sclk = sclk_o;
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [3:0] pre, input logic [RES-1:0] word);
    @(negedge clk);
    tx_bits = {pre, word};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 cs_n in reset", cs_n_o, 1'b1);
    chk("R1 sclk in reset", sclk_o, 1'b1);
    chk("R1 valid in reset", valid_o, 1'b0);
    chk("R1 busy in reset", busy_o, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    frame(4'h0, 12'hA5C);
    frame(4'h0, 12'hFFF);
    frame(4'h0, 12'h000);
    frame(4'h0, 12'h800);   // R4 msb
    frame(4'h0, 12'h001);   // R4 lsb
    frame(4'h8, 12'h3C3);   // R6 first prefix bit
    frame(4'h0, 12'h5A5);   // R6 flag clears
    frame(4'h1, 12'hFFF);   // R6 last prefix bit next to msb

    // R7 start mid-frame ignored
    @(negedge clk);
    tx_bits = {4'h0, 12'h7E1};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (40) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!cs_n_o) @(negedge clk);
    repeat (3) @(negedge clk);
    // R8 start in quiet time ignored
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();

    // R8 held start: back-to-back frames at minimum spacing
    @(negedge clk);
    tx_bits = {4'h0, 12'h123};
    start_i = 1'b1;
    repeat (3 * TOTAL) @(negedge clk);
    start_i = 1'b0;
    wait_idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule